// File: doc/BRIEF.md
# Keyed Flash Command Controller

This block sits between a processor's register bus and the timing port of a program-flash array. Software fills in a control word that holds the operation code, the erase qualifier and a write-enable. It then writes a page number and an in-page word offset. An erase of an eight-row block, or the programming of one row, begins only when an unlock key pair is written to the key register directly before the start bit is set. The key pair guards against stray writes that would otherwise start an operation.

When a start is accepted, the block pulses a start strobe to the flash port and presents an operation type together with an aligned word address. It then holds the processor stall output for a fixed number of clocks, and the start bit clears itself when that count runs out. A start attempt that is refused leaves the flash untouched and sets a sticky error flag that software can read.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: After reset, the control register (bus address 0) reads 16'h0000, and cpuStall and flashStart are low.
- R2: The sequence key 16'h0055, key 16'h00AA, then a control write of 16'hC042 (start bit 15, write-enable bit 14, erase bit 6, code 4'b0010) starts a block erase. flashStart pulses for exactly one cycle, flashOp is 2'b10, and cpuStall stays high for ERASE_CYC cycles.
- R3: The same key pair followed by 16'hC001 (code 4'b0001, erase bit 0) starts a row program. flashOp is 2'b01, and cpuStall stays high for PROG_CYC cycles.
- R4: Bit 15 of the control register reads 1 while an operation runs and clears by itself when it ends. The other control fields are kept.
- R5: A start attempt without the two key writes in order (0x55 first, then 0xAA), or with any other bus write between them or after them, is refused. No flashStart pulse occurs, cpuStall stays low, and bit 13 becomes 1.
- R6: A start attempt with bit 14 clear, with an unknown code, or with an erase bit that does not match the code is refused and sets bit 13.
- R7: Every start attempt uses up the unlock, whether it succeeds or not. A second attempt without new keys is refused.
- R8: Control writes made while busy are ignored. They do not restart the operation and do not change the fields.
- R9: Bit 13 is sticky. It stays 1 across later accepted operations and is cleared only by a control write with bit 13 at 0 while the block is idle.
- R10: flashAddr is {page (address 2), offset (address 3)}, captured at start. For an erase, the low 9 bits are cleared (64 words per row times 8 rows). For a program, the low 6 bits are cleared. Register addresses: 0 control, 1 key, 2 page, 3 offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register select (0 control, 1 key, 2 page, 3 offset) |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for busAddr (key reads 0) |
| cpuStall | output | 1 | High while an erase or program runs |
| flashStart | output | 1 | One-cycle start strobe to the flash port |
| flashOp | output | 2 | 2'b01 program row, 2'b10 erase block |
| flashAddr | output | PAGE_W+OFFS_W | Aligned start word address |

## Verification
A wrong unlock state shows up on the first start attempt that follows it. Either a start pulse appears in the cycle after a refused attempt, or none appears after a correct key pair. Either way, bit 13 disagrees when the control register is read back. A wrong down-counter shows as a stall window of the wrong length, which the bench measures edge by edge. Field corruption while busy appears in the control readback as soon as the operation ends.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;
  typedef enum logic [1:0] {OP_NONE = 2'b00, OP_PROG = 2'b01, OP_ERASE = 2'b10} flash_op_e;
  typedef enum logic [1:0] {UL_IDLE, UL_FIRST, UL_ARMED} unlock_e;

  typedef struct packed {
    logic ctlWrite;   // accepted control write (idle)
    logic launch;     // start accepted
    logic reject;     // start refused
    logic isErase;    // launched operation is an erase
  } strobe_t;

  localparam logic [1:0]  REG_CTL  = 2'd0;
  localparam logic [1:0]  REG_KEY  = 2'd1;
  localparam logic [1:0]  REG_PAGE = 2'd2;
  localparam logic [1:0]  REG_OFFS = 2'd3;
  localparam logic [15:0] KEY_FIRST  = 16'h0055;
  localparam logic [15:0] KEY_SECOND = 16'h00AA;
  localparam logic [3:0]  CODE_ERASE = 4'b0010;
  localparam logic [3:0]  CODE_PROG  = 4'b0001;
endpackage

// File: rtl/nvm_cmd_ctrl_fsm.sv
module nvm_cmd_ctrl_fsm
  import nvm_cmd_pkg::*;
#(
  parameter int ERASE_CYC = 16,
  parameter int PROG_CYC  = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWrEn,
  input  logic [1:0]    busAddr,
  input  logic [15:0]   busWrData,
  output strobe_t       strb,
  output logic          busy
);
  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  unlock_e          unlock;
  logic [CNT_W-1:0] cnt;
  logic ctlWr, keyWr, startReq, codeOk, goodStart, wantErase;

  assign ctlWr     = busWrEn && (busAddr == REG_CTL);
  assign keyWr     = busWrEn && (busAddr == REG_KEY);
  assign startReq  = ctlWr && !busy && busWrData[15];
  assign wantErase = (busWrData[3:0] == CODE_ERASE);
  assign codeOk    = (wantErase && busWrData[6]) ||
                     ((busWrData[3:0] == CODE_PROG) && !busWrData[6]);
  assign goodStart = startReq && (unlock == UL_ARMED) && busWrData[14] && codeOk;

  assign strb.ctlWrite = ctlWr && !busy;
  assign strb.launch   = goodStart;
  assign strb.reject   = startReq && !goodStart;
  assign strb.isErase  = wantErase;

  // Unlock tracker: only the exact next key advances it, any other write clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlock <= UL_IDLE;
    end else if (busWrEn) begin
      if (keyWr && busWrData == KEY_FIRST && unlock == UL_IDLE)
        unlock <= UL_FIRST;
      else if (keyWr && busWrData == KEY_SECOND && unlock == UL_FIRST)
        unlock <= UL_ARMED;
      else
        unlock <= UL_IDLE;
    end
  end

  // Busy window down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (goodStart) begin
      busy <= 1'b1;
      cnt  <= wantErase ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    busy && cnt != '0 |=> busy);
  a_r4_busy_ends: assert property (@(posedge clk) disable iff (!rstN)
    busy && cnt == '0 |=> !busy);
  a_r5_armed_after_first: assert property (@(posedge clk) disable iff (!rstN)
    unlock == UL_ARMED |-> $past(unlock) == UL_FIRST || $past(unlock) == UL_ARMED);
  a_r7_unlock_consumed: assert property (@(posedge clk) disable iff (!rstN)
    (strb.launch || strb.reject) |=> unlock == UL_IDLE);
endmodule

// File: rtl/nvm_cmd_ctrl_regs.sv
module nvm_cmd_ctrl_regs
  import nvm_cmd_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int OFFS_W    = 16,
  parameter int ROW_SHIFT = 6,
  parameter int BLK_SHIFT = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busWrEn,
  input  logic [1:0]               busAddr,
  input  logic [15:0]              busWrData,
  input  strobe_t                  strb,
  input  logic                     busy,
  output logic [15:0]              busRdData,
  output logic                     flashStart,
  output flash_op_e                flashOp,
  output logic [PAGE_W+OFFS_W-1:0] flashAddr
);
  localparam int ADDR_W = PAGE_W + OFFS_W;
  localparam logic [ADDR_W-1:0] BLK_MASK = {ADDR_W{1'b1}} << BLK_SHIFT;
  localparam logic [ADDR_W-1:0] ROW_MASK = {ADDR_W{1'b1}} << ROW_SHIFT;

  logic              wrEnBit, eraseBit, errBit;
  logic [3:0]        opCode;
  logic [PAGE_W-1:0] pageReg;
  logic [OFFS_W-1:0] offsReg;
  logic [ADDR_W-1:0] fullAddr;

  assign fullAddr = {pageReg, offsReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEnBit  <= 1'b0;
      eraseBit <= 1'b0;
      errBit   <= 1'b0;
      opCode   <= '0;
    end else if (strb.ctlWrite) begin
      wrEnBit  <= busWrData[14];
      eraseBit <= busWrData[6];
      opCode   <= busWrData[3:0];
      errBit   <= busWrData[13] | strb.reject;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
      offsReg <= '0;
    end else if (busWrEn) begin
      if (busAddr == REG_PAGE) pageReg <= busWrData[PAGE_W-1:0];
      if (busAddr == REG_OFFS) offsReg <= busWrData[OFFS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashStart <= 1'b0;
      flashOp    <= OP_NONE;
      flashAddr  <= '0;
    end else begin
      flashStart <= strb.launch;
      if (strb.launch) begin
        flashOp   <= strb.isErase ? OP_ERASE : OP_PROG;
        flashAddr <= fullAddr & (strb.isErase ? BLK_MASK : ROW_MASK);
      end
    end
  end

  always_comb begin
    case (busAddr)
      REG_CTL:  busRdData = {busy, wrEnBit, errBit, 6'b0, eraseBit, 2'b00, opCode};
      REG_PAGE: busRdData = 16'(pageReg);
      REG_OFFS: busRdData = 16'(offsReg);
      default:  busRdData = 16'h0000;
    endcase
  end

  a_r5_reject_sets_err: assert property (@(posedge clk) disable iff (!rstN)
    strb.reject |=> errBit);
  a_r8_busy_freezes: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(opCode) && $stable(wrEnBit) && $stable(eraseBit));
  a_r10_erase_aligned: assert property (@(posedge clk) disable iff (!rstN)
    flashStart && flashOp == OP_ERASE |-> flashAddr[BLK_SHIFT-1:0] == '0);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    flashStart |=> !flashStart);
endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
  import nvm_cmd_pkg::*;
#(
  parameter int PAGE_W         = 8,
  parameter int OFFS_W         = 16,
  parameter int ROW_WORDS      = 64,
  parameter int ROWS_PER_BLOCK = 8,
  parameter int ERASE_CYC      = 16,
  parameter int PROG_CYC       = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busWrEn,
  input  logic [1:0]               busAddr,
  input  logic [15:0]              busWrData,
  output logic [15:0]              busRdData,
  output logic                     cpuStall,
  output logic                     flashStart,
  output logic [1:0]               flashOp,
  output logic [PAGE_W+OFFS_W-1:0] flashAddr
);
  localparam int ROW_SHIFT = $clog2(ROW_WORDS);
  localparam int BLK_SHIFT = $clog2(ROW_WORDS * ROWS_PER_BLOCK);

  strobe_t   strb;
  logic      busy;
  flash_op_e opInt;

  nvm_cmd_ctrl_fsm #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_fsm (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .strb(strb), .busy(busy)
  );

  nvm_cmd_ctrl_regs #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W),
                      .ROW_SHIFT(ROW_SHIFT), .BLK_SHIFT(BLK_SHIFT)) u_regs (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .strb(strb), .busy(busy), .busRdData(busRdData),
    .flashStart(flashStart), .flashOp(opInt), .flashAddr(flashAddr)
  );

  assign cpuStall = busy;
  assign flashOp  = opInt;
endmodule

// File: tb/nvm_cmd_ctrl_test.sv
module nvm_cmd_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ERASE_CYC  = 16;
  localparam int PROG_CYC   = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [15:0] busWrData = 16'h0;
  logic [15:0] busRdData;
  logic        cpuStall, flashStart;
  logic [1:0]  flashOp;
  logic [23:0] flashAddr;

  int compared = 0;
  int mismatched = 0;
  int stallCnt = 0;
  int startCnt = 0;

  nvm_cmd_ctrl #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .cpuStall(cpuStall),
    .flashStart(flashStart), .flashOp(flashOp), .flashAddr(flashAddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rstN) begin
      if (cpuStall)   stallCnt = stallCnt + 1;
      if (flashStart) startCnt = startCnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 2'd0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] d);
    busAddr = a;
    #1;
    d = busRdData;
    busAddr = 2'd0;
  endtask

  task automatic waitIdle();
    while (cpuStall) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic unlockKeys();
    busWrite(2'd1, 16'h0055);
    busWrite(2'd1, 16'h00AA);
  endtask

  // R1
  task automatic testReset();
    logic [15:0] r;
    readReg(2'd0, r);
    chk("R1 control after reset", r, 16'h0000);
    chk("R1 stall after reset", cpuStall, 1'b0);
    chk("R1 start after reset", flashStart, 1'b0);
  endtask

  // R2, R4, R10
  task automatic testErase();
    logic [15:0] r;
    int s0, p0;
    busWrite(2'd2, 16'h0012);
    busWrite(2'd3, 16'h3456);
    s0 = stallCnt; p0 = startCnt;
    unlockKeys();
    busWrite(2'd0, 16'hC042);
    chk("R2 erase start pulse", flashStart, 1'b1);
    chk("R2 erase op code", flashOp, 2'b10);
    chk("R10 erase block address", flashAddr, 24'h123400);
    readReg(2'd0, r);
    chk("R4 busy bit during erase", r[15], 1'b1);
    @(negedge clk);
    chk("R2 start pulse one cycle", flashStart, 1'b0);
    waitIdle();
    chk("R2 erase stall length", stallCnt - s0, ERASE_CYC);
    chk("R2 erase one pulse", startCnt - p0, 1);
    readReg(2'd0, r);
    chk("R4 busy clears, fields kept", r, 16'h4042);
  endtask

  // R3, R8, R10
  task automatic testProgram();
    logic [15:0] r;
    int s0, p0;
    s0 = stallCnt; p0 = startCnt;
    unlockKeys();
    busWrite(2'd0, 16'hC001);
    chk("R3 program op code", flashOp, 2'b01);
    chk("R10 program row address", flashAddr, 24'h123440);
    busWrite(2'd0, 16'hC042);
    waitIdle();
    chk("R3 program stall length", stallCnt - s0, PROG_CYC);
    chk("R8 no restart while busy", startCnt - p0, 1);
    readReg(2'd0, r);
    chk("R8 fields unchanged by busy write", r, 16'h4001);
  endtask

  // R5, R9
  task automatic testBadOrder();
    logic [15:0] r;
    int s0, p0;
    s0 = stallCnt; p0 = startCnt;
    busWrite(2'd1, 16'h00AA);
    busWrite(2'd1, 16'h0055);
    busWrite(2'd0, 16'hC042);
    @(negedge clk);
    chk("R5 reversed keys no start", startCnt - p0, 0);
    chk("R5 reversed keys no stall", stallCnt - s0, 0);
    readReg(2'd0, r);
    chk("R5 reversed keys error bit", r, 16'h6042);
    busWrite(2'd0, 16'h0000);
    readReg(2'd0, r);
    chk("R9 error cleared by writing 0", r, 16'h0000);
    p0 = startCnt;
    busWrite(2'd1, 16'h0055);
    busWrite(2'd2, 16'h0012);
    busWrite(2'd1, 16'h00AA);
    busWrite(2'd0, 16'hC042);
    @(negedge clk);
    chk("R5 interposed write no start", startCnt - p0, 0);
    readReg(2'd0, r);
    chk("R5 interposed write error bit", r[13], 1'b1);
    busWrite(2'd0, 16'h0000);
  endtask

  // R6
  task automatic testBadCommand();
    logic [15:0] r;
    int p0;
    p0 = startCnt;
    unlockKeys();
    busWrite(2'd0, 16'h8042);
    readReg(2'd0, r);
    chk("R6 write-enable clear error", r[13], 1'b1);
    busWrite(2'd0, 16'h0000);
    unlockKeys();
    busWrite(2'd0, 16'hC003);
    readReg(2'd0, r);
    chk("R6 unknown code error", r[13], 1'b1);
    busWrite(2'd0, 16'h0000);
    unlockKeys();
    busWrite(2'd0, 16'hC041);
    readReg(2'd0, r);
    chk("R6 erase bit mismatch error", r[13], 1'b1);
    @(negedge clk);
    chk("R6 no start on bad commands", startCnt - p0, 0);
    busWrite(2'd0, 16'h0000);
  endtask

  // R7, R9
  task automatic testConsumeAndSticky();
    logic [15:0] r;
    int p0;
    p0 = startCnt;
    unlockKeys();
    busWrite(2'd0, 16'h8042);
    busWrite(2'd0, 16'hC042);
    @(negedge clk);
    chk("R7 retry without keys refused", startCnt - p0, 0);
    unlockKeys();
    busWrite(2'd0, 16'hE042);
    chk("R7 fresh keys accepted", flashStart, 1'b1);
    waitIdle();
    readReg(2'd0, r);
    chk("R9 error sticky across operation", r, 16'h6042);
    busWrite(2'd0, 16'h4042);
    readReg(2'd0, r);
    chk("R9 error cleared when idle", r, 16'h4042);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testErase();
    testProgram();
    testBadOrder();
    testBadCommand();
    testConsumeAndSticky();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule